// File: doc/BRIEF.md
# Parallel-Prefix Carry-Lookahead Adder

This block adds two unsigned operands of `WIDTH` bits together with a single carry-in bit and returns a `WIDTH`-bit sum plus a carry-out. It is purely combinational. Every bit position first derives a local generate flag, set when both operand bits are 1, and a local propagate flag, set when exactly one of them is 1. Neither flag needs any carry. A recursive parallel-prefix network then merges these pairs with the associative combine rule `G = g_hi | (p_hi & g_lo)`, `P = p_hi & p_lo`. The network pairs neighbouring positions, solves the half-width prefix by recursion, and finally fixes up the even positions. Its depth therefore grows with log2(`WIDTH`) and its gate count grows linearly. After that, a single XOR level forms the sum bits.

The carry-in is merged on top of each prefix term as the lowest-order contribution, so `c[i+1] = G[i:0] | (P[i:0] & cin)`. The same prefix output for the whole word is exported as a group generate / group propagate pair. It is also exported as a 2-bit classification that says whether the block swallows, forwards or creates a carry. An enclosing adder can then stitch several instances together without waiting for their sums. Under that stitching, an upper unit that absorbs or generates decides the combined result, and an upper unit that propagates takes the lower unit's class.

The status decoder works as a small named-state selector with three states. `ST_ABSORB` is entered when the carry-free sum is below 2^WIDTH-1. `ST_PROP` is entered when the carry-free sum is exactly 2^WIDTH-1. `ST_GEN` is entered when the carry-free sum has bit `WIDTH` set. Which state is active is a pure function of the operands, and the carry-in has no effect on it.

Top module: `pp_cla_adder`

## Requirements
- R1: `sum_o` equals bits WIDTH-1..0 of the unsigned value `a_i + b_i + cin_i`.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`.
- R3: `grp_gen_o` is 1 exactly when the carry-free sum `a_i + b_i` is at least 2^WIDTH, whatever the value of `cin_i`.
- R4: `grp_prop_o` is 1 exactly when the carry-free sum `a_i + b_i` equals 2^WIDTH-1, which means every bit position has exactly one operand bit set.
- R5: `status_o` encodes the block class as 2'b00 absorb, 2'b01 propagate and 2'b10 generate. It is 2'b10 when R3 holds, 2'b01 when R4 holds, and 2'b00 otherwise. The value 2'b11 never appears.
- R6: For either carry-in value, `cout_o` equals `grp_gen_o | (grp_prop_o & cin_i)`. Under absorb the carry-out is 0, under generate it is 1, and under propagate it equals `cin_i`.
- R7: All-ones operand `a_i` with zero `b_i` and `cin_i`=1 gives `sum_o`=0, `cout_o`=1 and status 2'b01. Zero operands with `cin_i`=0 give all outputs 0 and status 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| grp_gen_o | output | 1 | Whole block creates a carry regardless of carry-in |
| grp_prop_o | output | 1 | Whole block forwards the carry-in unchanged |
| status_o | output | 2 | Block class: 00 absorb, 01 propagate, 10 generate |

## Verification
The checker's immediate assertions take for granted that all three inputs carry defined two-state values and are evaluated only after the combinational network has settled. A transient mix of old and new operand bits would break the arithmetic identities. The bench therefore changes `a_i`, `b_i` and `cin_i` together, in one step, just after a rising clock edge. It reads the outputs only at the following falling edge. Every vector is applied with both carry-in values, so the absorb, propagate and generate classes are each seen against both carry-in levels.

// File: rtl/pp_cla_pkg.sv
package pp_cla_pkg;

    // Classification of a block with respect to an incoming carry
    typedef enum logic [1:0] {
        ST_ABSORB = 2'b00,
        ST_PROP   = 2'b01,
        ST_GEN    = 2'b10
    } carry_class_e;

    // Generate half of the associative (G,P) combine: hi over lo
    function automatic logic comb_gen(input logic g_hi, input logic p_hi,
                                      input logic g_lo);
        return g_hi | (p_hi & g_lo);
    endfunction

    // Propagate half of the associative (G,P) combine
    function automatic logic comb_prop(input logic p_hi, input logic p_lo);
        return p_hi & p_lo;
    endfunction

endpackage

// File: rtl/pp_cla_gp_gen.sv
module pp_cla_gp_gen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);

    // Per-position flags, independent of every carry
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign g_o[i] = a_i[i] & b_i[i];
        assign p_o[i] = a_i[i] ^ b_i[i];
    end

endmodule

// File: rtl/pp_cla_prefix.sv
// Recursive prefix network: out[i] = in[i] o in[i-1] o ... o in[0]
module pp_cla_prefix
    import pp_cla_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    output logic [N-1:0] g_o,
    output logic [N-1:0] p_o
);

    if (N == 1) begin : g_leaf
        assign g_o = g_i;
        assign p_o = p_i;
    end else begin : g_node
        localparam int HALF = N / 2;
        localparam int NEVEN = (N - 1) / 2;

        logic [HALF-1:0] pair_g;
        logic [HALF-1:0] pair_p;
        logic [HALF-1:0] sub_g;
        logic [HALF-1:0] sub_p;

        // Step 1: merge neighbouring positions (2j+1 over 2j)
        for (genvar j = 0; j < HALF; j++) begin : g_pair
            assign pair_g[j] = comb_gen(g_i[2*j+1], p_i[2*j+1], g_i[2*j]);
            assign pair_p[j] = comb_prop(p_i[2*j+1], p_i[2*j]);
        end

        // Step 2: half-width prefix over the merged pairs
        pp_cla_prefix #(.N(HALF)) u_sub (
            .g_i (pair_g),
            .p_i (pair_p),
            .g_o (sub_g),
            .p_o (sub_p)
        );

        // Step 3: odd positions are finished by the sub-network
        for (genvar j = 0; j < HALF; j++) begin : g_odd
            assign g_o[2*j+1] = sub_g[j];
            assign p_o[2*j+1] = sub_p[j];
        end

        // Step 4: even positions need one fix-up combine
        assign g_o[0] = g_i[0];
        assign p_o[0] = p_i[0];
        for (genvar j = 1; j <= NEVEN; j++) begin : g_even
            assign g_o[2*j] = comb_gen(g_i[2*j], p_i[2*j], sub_g[j-1]);
            assign p_o[2*j] = comb_prop(p_i[2*j], sub_p[j-1]);
        end
    end

endmodule

// File: rtl/pp_cla_carry_sum.sv
module pp_cla_carry_sum
    import pp_cla_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] p_i,     // per-bit propagate
    input  logic [WIDTH-1:0] pg_i,    // prefix generate of bits i..0
    input  logic [WIDTH-1:0] pp_i,    // prefix propagate of bits i..0
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] carry;

    // Carry-in merged as the lowest-order (cin,0) term of each prefix
    assign carry[0] = cin_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
        assign carry[i+1] = comb_gen(pg_i[i], pp_i[i], cin_i);
    end

    // Single XOR level for the sum
    assign sum_o  = p_i ^ carry[WIDTH-1:0];
    assign cout_o = carry[WIDTH];

endmodule

// File: rtl/pp_cla_status_enc.sv
module pp_cla_status_enc
    import pp_cla_pkg::*;
(
    input  logic       grp_gen_i,
    input  logic       grp_prop_i,
    output logic [1:0] status_o
);

    carry_class_e cls;

    always_comb begin
        unique case ({grp_gen_i, grp_prop_i})
            2'b10:   cls = ST_GEN;
            2'b01:   cls = ST_PROP;
            2'b00:   cls = ST_ABSORB;
            default: cls = ST_ABSORB;
        endcase
    end

    assign status_o = cls;

endmodule

// File: rtl/pp_cla_adder.sv
module pp_cla_adder
    import pp_cla_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             grp_gen_o,
    output logic             grp_prop_o,
    output logic [1:0]       status_o
);

    logic [WIDTH-1:0] bit_g;
    logic [WIDTH-1:0] bit_p;
    logic [WIDTH-1:0] pre_g;
    logic [WIDTH-1:0] pre_p;

    pp_cla_gp_gen #(.WIDTH(WIDTH)) u_gp (
        .a_i (a_i),
        .b_i (b_i),
        .g_o (bit_g),
        .p_o (bit_p)
    );

    pp_cla_prefix #(.N(WIDTH)) u_prefix (
        .g_i (bit_g),
        .p_i (bit_p),
        .g_o (pre_g),
        .p_o (pre_p)
    );

    pp_cla_carry_sum #(.WIDTH(WIDTH)) u_cs (
        .p_i    (bit_p),
        .pg_i   (pre_g),
        .pp_i   (pre_p),
        .cin_i  (cin_i),
        .sum_o  (sum_o),
        .cout_o (cout_o)
    );

    // Whole-word prefix term is the group status
    assign grp_gen_o  = pre_g[WIDTH-1];
    assign grp_prop_o = pre_p[WIDTH-1];

    pp_cla_status_enc u_stat (
        .grp_gen_i  (grp_gen_o),
        .grp_prop_i (grp_prop_o),
        .status_o   (status_o)
    );

endmodule

// File: rtl/pp_cla_adder_chk.sv
module pp_cla_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic             grp_gen_o,
    input logic             grp_prop_o,
    input logic [1:0]       status_o
);

    logic [WIDTH:0] full_ref;
    logic [WIDTH:0] nocin_ref;

    always_comb begin
        full_ref  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        nocin_ref = {1'b0, a_i} + {1'b0, b_i};

        // R1
        sum_match_chk: assert ({cout_o, sum_o} == full_ref || cout_o != full_ref[WIDTH]
                               || sum_o == full_ref[WIDTH-1:0])
            else $error("sum mismatch");
        // R2
        cout_match_chk: assert (cout_o == full_ref[WIDTH])
            else $error("carry-out mismatch");
        // R3
        grp_gen_chk: assert (grp_gen_o == nocin_ref[WIDTH])
            else $error("group generate mismatch");
        // R4
        grp_prop_chk: assert (grp_prop_o == (nocin_ref == {1'b0, {WIDTH{1'b1}}}))
            else $error("group propagate mismatch");
        // R5
        status_legal_chk: assert (status_o != 2'b11 && !(grp_gen_o && grp_prop_o))
            else $error("illegal status code");
        // R6
        class_cout_chk: assert ((status_o == 2'b00 && !cout_o) ||
                                (status_o == 2'b10 && cout_o) ||
                                (status_o == 2'b01 && cout_o == cin_i))
            else $error("status inconsistent with carry-out");
    end

endmodule

bind pp_cla_adder pp_cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i        (a_i),
    .b_i        (b_i),
    .cin_i      (cin_i),
    .sum_o      (sum_o),
    .cout_o     (cout_o),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o),
    .status_o   (status_o)
);

// File: tb/pp_cla_adder_tb.sv
`timescale 1ns/1ps
module pp_cla_adder_tb;

    localparam int W = 32;
    localparam int MAX_CYC = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    logic         gg;
    logic         gp;
    logic [1:0]   st;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pp_cla_adder #(.WIDTH(W)) u_dut (
        .a_i        (a),
        .b_i        (b),
        .cin_i      (cin),
        .sum_o      (sum),
        .cout_o     (cout),
        .grp_gen_o  (gg),
        .grp_prop_o (gp),
        .status_o   (st)
    );

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, act, exp);
        end
    endtask

    // Apply one vector and check every output against the arithmetic model
    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
        logic [W:0] full;
        logic [W:0] nocin;
        logic       e_gen;
        logic       e_prop;
        logic [1:0] e_st;
        @(posedge clk);
        #1;
        a = av; b = bv; cin = cv;
        @(negedge clk);
        full   = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
        nocin  = {1'b0, av} + {1'b0, bv};
        e_gen  = nocin[W];
        e_prop = !nocin[W] && (nocin[W-1:0] == {W{1'b1}});
        e_st   = e_gen ? 2'b10 : (e_prop ? 2'b01 : 2'b00);
        chk("R1 sum", {1'b0, sum}, {1'b0, full[W-1:0]});
        chk("R2 cout", {{W{1'b0}}, cout}, {{W{1'b0}}, full[W]});
        chk("R3 grp_gen", {{W{1'b0}}, gg}, {{W{1'b0}}, e_gen});
        chk("R4 grp_prop", {{W{1'b0}}, gp}, {{W{1'b0}}, e_prop});
        chk("R5 status", {{(W-1){1'b0}}, st}, {{(W-1){1'b0}}, e_st});
        chk("R6 class/cout", {{W{1'b0}}, cout}, {{W{1'b0}}, (gg | (gp & cv))});
    endtask

    task automatic apply_both(input logic [W-1:0] av, input logic [W-1:0] bv);
        apply(av, bv, 1'b0);
        apply(av, bv, 1'b1);
    endtask

    task automatic t_reset_state;
        // R7: zero operands, zero carry-in
        apply('0, '0, 1'b0);
        chk("R7 zero sum", {1'b0, sum}, '0);
        chk("R7 zero status", {{(W-1){1'b0}}, st}, '0);
    endtask

    task automatic t_all_ones_cin;
        // R7: all ones plus carry-in wraps to zero, propagate class
        apply({W{1'b1}}, '0, 1'b1);
        chk("R7 wrap sum", {1'b0, sum}, '0);
        chk("R7 wrap cout", {{W{1'b0}}, cout}, {{W{1'b0}}, 1'b1});
        chk("R7 wrap status", {{(W-1){1'b0}}, st}, {{(W-1){1'b0}}, 2'b01});
        apply({W{1'b1}}, '0, 1'b0);
    endtask

    task automatic t_alternating;
        apply_both({(W/2){2'b10}}, {(W/2){2'b01}});   // R4 propagate class
        apply_both({(W/2){2'b10}}, {(W/2){2'b10}});   // R3 generate class
        apply_both({(W/2){2'b01}}, {(W/2){2'b01}});   // absorb class
    endtask

    task automatic t_edges;
        apply_both({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}); // R3 top bits only
        apply_both({W{1'b1}}, {W{1'b1}});                          // R3 max + max
        apply_both({W{1'b1}}, {{(W-1){1'b0}}, 1'b1});              // R2 full ripple
        apply_both({1'b0, {(W-1){1'b1}}}, {1'b1, {(W-1){1'b0}}});  // R4 split prop
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (k % 8 == 0) rb = ~ra;   // R4 force propagate class often
            apply_both(ra, rb);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_all_ones_cin();
        t_alternating();
        t_edges();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", MAX_CYC, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule